// File: doc/BRIEF.md
# Unsigned Long Multiply-Accumulate Unit

This datapath unit forms the full 64-bit product of two unsigned 32-bit operands. It can return that product as it is. It can add it to a 64-bit accumulator built from a high word and a low word. It can also add two separate 32-bit words to the product. The result leaves as a high word and a low word. The unit never produces condition flags. The surrounding core supplies the operands, the current accumulator words, a 2-bit operation code and the four register indices it intends to use. The unit writes nothing back itself.

Requests enter with a one-cycle valid strobe. The answer comes out a fixed number of cycles later, set by the `LAT` parameter (1 to 3). A new request may be accepted every cycle. Alongside each answer the unit raises an illegal flag when the request breaks the register-use rules or uses the reserved operation code.

Top module: `lmac_unit`

## Requirements
- R1: With op code 2'b00 (plain), the result {res_hi,res_lo} equals opa*opb as a 64-bit unsigned product, and acc_hi/acc_lo have no effect on it.
- R2: With op code 2'b01 (wide accumulate), the result equals opa*opb + {acc_hi,acc_lo} modulo 2^64, with no saturation and no carry reported.
- R3: With op code 2'b10 (split accumulate), the result equals opa*opb + acc_hi + acc_lo, each word zero-extended. This sum never exceeds 2^64-1, and all-ones on all four inputs gives exactly 2^64-1.
- R4: Op code 2'b11 is reserved. Such a request is flagged illegal and returns a result of zero.
- R5: When dst_hi equals dst_lo, the request is flagged illegal. The arithmetic result is still delivered.
- R6: When any of idx_a, idx_b, dst_hi or dst_lo equals 13 or 15, the request is flagged illegal. The arithmetic result is still delivered.
- R7: out_valid is high exactly LAT cycles after each cycle in which in_valid was high, and low otherwise. Reset clears it.
- R8: While out_valid is low, illegal, res_hi and res_lo are all zero. A legal request returns illegal low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request strobe, one request per cycle |
| op | input | 2 | Operation code: 00 plain, 01 wide accumulate, 10 split accumulate, 11 reserved |
| opa | input | 32 | First unsigned operand |
| opb | input | 32 | Second unsigned operand |
| acc_hi | input | 32 | Current high accumulator word |
| acc_lo | input | 32 | Current low accumulator word |
| idx_a | input | 4 | Register index of the first operand |
| idx_b | input | 4 | Register index of the second operand |
| dst_hi | input | 4 | Register index for the high result |
| dst_lo | input | 4 | Register index for the low result |
| out_valid | output | 1 | Result strobe |
| res_hi | output | 32 | High 32 bits of the result |
| res_lo | output | 32 | Low 32 bits of the result |
| illegal | output | 1 | Request broke a register rule or used the reserved code |

## Verification
Every result, and its illegal flag, is due exactly LAT rising edges after the edge that captured the request, and stays there for a single cycle. The bench drives each request on a falling edge and lowers in_valid at the next falling edge. It then waits LAT-1 further falling edges and compares all outputs there, against a 64-bit model computed in the bench. One falling edge later it confirms that out_valid has dropped and that the outputs are back to zero. The sweep crosses all four op codes with eight corner values on each of the four data inputs, then adds pseudo-random operands and every combination of the index values.

// File: rtl/lmac_pkg.sv
package lmac_pkg;

    localparam int WORD_W = 32;
    localparam int IDX_W  = 4;
    localparam int PROD_W = 2 * WORD_W;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [IDX_W-1:0]  ridx_t;

    typedef enum logic [1:0] {
        OP_PLAIN      = 2'b00,
        OP_ACC_WIDE   = 2'b01,
        OP_ACC_SPLIT  = 2'b10,
        OP_RESERVED   = 2'b11
    } op_e;

    localparam ridx_t IDX_STACK = ridx_t'(13);
    localparam ridx_t IDX_PCNT  = ridx_t'(15);

    typedef struct packed {
        logic  valid;
        logic  illegal;
        word_t hi;
        word_t lo;
    } beat_t;

    function automatic logic idx_banned(input ridx_t i);
        return (i == IDX_STACK) || (i == IDX_PCNT);
    endfunction

endpackage

// File: rtl/lmac_rule_check.sv
module lmac_rule_check
    import lmac_pkg::*;
(
    input  op_e   op,
    input  ridx_t idx_a,
    input  ridx_t idx_b,
    input  ridx_t dst_hi,
    input  ridx_t dst_lo,
    output logic  bad
);
    logic same_dst;
    logic banned_any;
    logic rsvd_op;

    always_comb begin
        same_dst   = (dst_hi == dst_lo);
        banned_any = idx_banned(idx_a) | idx_banned(idx_b)
                   | idx_banned(dst_hi) | idx_banned(dst_lo);
        rsvd_op    = (op == OP_RESERVED);
        bad        = same_dst | banned_any | rsvd_op;
    end
endmodule

// File: rtl/lmac_arith.sv
module lmac_arith
    import lmac_pkg::*;
(
    input  op_e   op,
    input  word_t opa,
    input  word_t opb,
    input  word_t acc_hi,
    input  word_t acc_lo,
    output word_t res_hi,
    output word_t res_lo
);
    logic [PROD_W-1:0] product;
    logic [PROD_W:0]   split_sum;
    logic [PROD_W-1:0] total;

    always_comb begin
        product   = PROD_W'(opa) * PROD_W'(opb);
        split_sum = (PROD_W+1)'(product) + (PROD_W+1)'(acc_hi)
                  + (PROD_W+1)'(acc_lo);
        unique case (op)
            OP_PLAIN:     total = product;
            OP_ACC_WIDE:  total = product + {acc_hi, acc_lo};
            OP_ACC_SPLIT: total = split_sum[PROD_W-1:0];
            default:      total = '0;
        endcase
        res_hi = total[PROD_W-1:WORD_W];
        res_lo = total[WORD_W-1:0];
    end

    // R3
    always_comb begin
        split_no_carry_chk: assert (split_sum[PROD_W] == 1'b0);
    end
endmodule

// File: rtl/lmac_delay.sv
module lmac_delay
    import lmac_pkg::*;
#(
    parameter int DEPTH = 1
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t d,
    output beat_t q
);
    beat_t stage [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= d;
            end
        end else begin : g_rest
            always_ff @(posedge clk) begin
                if (rst) stage[g] <= '0;
                else     stage[g] <= stage[g-1];
            end
        end
    end

    assign q = stage[DEPTH-1];
endmodule

// File: rtl/lmac_unit.sv
module lmac_unit
    import lmac_pkg::*;
#(
    parameter int LAT = 1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [1:0]  op,
    input  logic [31:0] opa,
    input  logic [31:0] opb,
    input  logic [31:0] acc_hi,
    input  logic [31:0] acc_lo,
    input  logic [3:0]  idx_a,
    input  logic [3:0]  idx_b,
    input  logic [3:0]  dst_hi,
    input  logic [3:0]  dst_lo,
    output logic        out_valid,
    output logic [31:0] res_hi,
    output logic [31:0] res_lo,
    output logic        illegal
);
    op_e   op_sel;
    word_t calc_hi;
    word_t calc_lo;
    logic  rule_bad;
    beat_t head;
    beat_t tail;

    assign op_sel = op_e'(op);

    lmac_rule_check u_rules (
        .op     (op_sel),
        .idx_a  (idx_a),
        .idx_b  (idx_b),
        .dst_hi (dst_hi),
        .dst_lo (dst_lo),
        .bad    (rule_bad)
    );

    lmac_arith u_arith (
        .op     (op_sel),
        .opa    (opa),
        .opb    (opb),
        .acc_hi (acc_hi),
        .acc_lo (acc_lo),
        .res_hi (calc_hi),
        .res_lo (calc_lo)
    );

    always_comb begin
        head.valid   = in_valid;
        head.illegal = in_valid & rule_bad;
        head.hi      = in_valid ? calc_hi : '0;
        head.lo      = in_valid ? calc_lo : '0;
    end

    lmac_delay #(.DEPTH(LAT)) u_delay (
        .clk (clk),
        .rst (rst),
        .d   (head),
        .q   (tail)
    );

    assign out_valid = tail.valid;
    assign illegal   = tail.illegal;
    assign res_hi    = tail.hi;
    assign res_lo    = tail.lo;

    // R7
    valid_latency_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid == $past(in_valid, LAT));

    // R5
    same_dst_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && dst_hi == dst_lo) |-> ##LAT (out_valid && illegal));

    // R6
    banned_idx_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (idx_a == 4'd13 || idx_a == 4'd15 || idx_b == 4'd13 ||
                      idx_b == 4'd15 || dst_hi == 4'd13 || dst_hi == 4'd15 ||
                      dst_lo == 4'd13 || dst_lo == 4'd15))
        |-> ##LAT (out_valid && illegal));

    // R4
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op == 2'b11)
        |-> ##LAT (illegal && res_hi == '0 && res_lo == '0));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!illegal && res_hi == '0 && res_lo == '0));
endmodule

// File: tb/lmac_unit_test.sv
module lmac_unit_test;
    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic [31:0] opa = '0, opb = '0, acc_hi = '0, acc_lo = '0;
    logic [3:0]  idx_a = 4'd0, idx_b = 4'd1, dst_hi = 4'd2, dst_lo = 4'd3;
    logic        out_valid, illegal;
    logic [31:0] res_hi, res_lo;

    int checks = 0;
    int fails  = 0;
    logic [31:0] corner [8];

    always #10 clk = ~clk;

    lmac_unit #(.LAT(LAT)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .opa(opa), .opb(opb), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .idx_a(idx_a), .idx_b(idx_b), .dst_hi(dst_hi), .dst_lo(dst_lo),
        .out_valid(out_valid), .res_hi(res_hi), .res_lo(res_lo),
        .illegal(illegal)
    );

    function automatic logic [63:0] model(input logic [1:0] m,
        input logic [31:0] a, input logic [31:0] b,
        input logic [31:0] h, input logic [31:0] l);
        logic [63:0] p;
        p = {32'd0, a} * {32'd0, b};
        case (m)
            2'b00:   return p;
            2'b01:   return p + {h, l};
            2'b10:   return p + {32'd0, h} + {32'd0, l};
            default: return 64'd0;
        endcase
    endfunction

    function automatic logic banned(input logic [3:0] i);
        return i == 4'd13 || i == 4'd15;
    endfunction

    task automatic run_op(input logic [1:0] m, input logic [31:0] a,
        input logic [31:0] b, input logic [31:0] h, input logic [31:0] l,
        input logic [3:0] ia, input logic [3:0] ib,
        input logic [3:0] dh, input logic [3:0] dl, input string req);
        logic [63:0] exp_res;
        logic        exp_bad;
        exp_res = model(m, a, b, h, l);
        exp_bad = (m == 2'b11) || (dh == dl) || banned(ia) || banned(ib)
                || banned(dh) || banned(dl);
        @(negedge clk);
        in_valid = 1'b1; op = m; opa = a; opb = b; acc_hi = h; acc_lo = l;
        idx_a = ia; idx_b = ib; dst_hi = dh; dst_lo = dl;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT - 1) @(negedge clk);
        checks++;
        if (!out_valid || {res_hi, res_lo} != exp_res || illegal != exp_bad) begin
            fails++;
            $display("FAIL %s: op=%b a=%h b=%h h=%h l=%h got v=%b res=%h ill=%b exp v=1 res=%h ill=%b",
                     req, m, a, b, h, l, out_valid, {res_hi, res_lo}, illegal,
                     exp_res, exp_bad);
        end
        @(negedge clk);
        checks++;  // R7 strobe lasts one cycle, R8 outputs quiet after it
        if (out_valid || illegal || res_hi != 0 || res_lo != 0) begin
            fails++;
            $display("FAIL R7/R8 drop: got v=%b ill=%b res=%h exp v=0 ill=0 res=0",
                     out_valid, illegal, {res_hi, res_lo});
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: got timeout exp completion");
        $display("%0d/%0d checks passed", checks - fails + 1 - 1, checks + 1);
        $finish;
    end

    initial begin
        corner[0] = 32'h0000_0000; corner[1] = 32'h0000_0001;
        corner[2] = 32'hFFFF_FFFF; corner[3] = 32'hFFFF_FFFE;
        corner[4] = 32'h8000_0000; corner[5] = 32'h7FFF_FFFF;
        corner[6] = 32'h0001_0000; corner[7] = 32'h0000_0002;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;  // R7 reset state
        if (out_valid || illegal || res_hi != 0 || res_lo != 0) begin
            fails++;
            $display("FAIL R7 reset: got v=%b ill=%b res=%h exp all zero",
                     out_valid, illegal, {res_hi, res_lo});
        end

        // R3 maximum corner: exactly 2^64-1
        run_op(2'b10, '1, '1, '1, '1, 4'd0, 4'd1, 4'd2, 4'd3, "R3 max");
        // R2 wrap past 2^64
        run_op(2'b01, '1, '1, '1, '1, 4'd0, 4'd1, 4'd2, 4'd3, "R2 wrap");

        // R1 R2 R3 R4 sweep of all op codes over corner values
        for (int m = 0; m < 4; m++)
            for (int i = 0; i < 8; i++)
                for (int j = 0; j < 8; j++)
                    for (int k = 0; k < 8; k++)
                        for (int n = 0; n < 8; n++)
                            run_op(2'(m), corner[i], corner[j], corner[k], corner[n],
                                   4'd4, 4'd5, 4'd6, 4'd7,
                                   m == 0 ? "R1" : m == 1 ? "R2" : m == 2 ? "R3" : "R4");

        // single-bit operands
        for (int s = 0; s < 32; s++)
            for (int m = 0; m < 3; m++)
                run_op(2'(m), 32'd1 << s, 32'd1 << (31 - s), 32'd1 << s, '1,
                       4'd0, 4'd1, 4'd2, 4'd3, "R1/R2/R3 bit");

        // pseudo-random operands
        for (int r = 0; r < 600; r++)
            run_op(2'(r % 4), $urandom, $urandom, $urandom, $urandom,
                   4'd8, 4'd9, 4'd10, 4'd11, "R1/R2/R3/R4 rnd");

        // R5 R6 R8: every destination pair
        for (int dh = 0; dh < 16; dh++)
            for (int dl = 0; dl < 16; dl++)
                run_op(2'b00, 32'h1234_5678, 32'h9ABC_DEF0, '1, '1,
                       4'd0, 4'd1, 4'(dh), 4'(dl), "R5/R6/R8 dst");
        // R6 R8: every source index
        for (int x = 0; x < 16; x++) begin
            run_op(2'b01, 32'hDEAD_BEEF, 32'h0000_0003, 32'd5, 32'd7,
                   4'(x), 4'd1, 4'd2, 4'd3, "R6/R8 idx_a");
            run_op(2'b10, 32'h0000_0003, 32'hDEAD_BEEF, 32'd5, 32'd7,
                   4'd0, 4'(x), 4'd2, 4'd3, "R6/R8 idx_b");
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule